// File: doc/BRIEF.md
# Pipeline Trap Tracking and Flush Unit

This block follows trap instructions through a four-stage in-order integer pipeline (fetch, decode, execute, memory) with a writeback register behind it. Every stage register holds the instruction word, its address and a two-bit trap cause. Decode gives a cause to the two trap instructions. The cause then travels with its instruction until the instruction reaches the memory stage. Only there is the trap committed.

In the cycle the memory stage holds a trapping instruction, the unit does four things. It holds the data-access strobes of that instruction low. It marks the instruction so that it writes no register in writeback. It raises a redirect strobe whose target is the trap address plus four. It also raises a break pulse when the cause is a breakpoint. On the next clock edge the fetch, decode and execute registers, and the entry into the memory stage, become bubbles, and the fetch input of that edge is dropped. The older instruction already in writeback is left alone. The pipeline advances every cycle. A fetch slot with `fetch_valid` low loads a bubble.

Top module: `trap_pipe_top`

## Requirements
- R1: After reset, and for every bubble, a stage holds instruction 0, address 0 and cause none. The cause encoding is none=0, breakpoint=1, system call=2. All strobes are low in reset.
- R2: When an instruction enters decode with opcode bits [31:26]=0, it gets cause system call if function bits [5:0]=12 and cause breakpoint if they are 13. Any other instruction gets cause none.
- R3: Each cycle the address and cause move one stage (F to D to E to M) with their instruction. A cause that is already set is never replaced, and fetch always records cause none.
- R4: A fetch slot with `fetch_valid` low loads a bubble into fetch whatever the instruction input holds, and that slot never causes a redirect.
- R5: While the memory stage holds a cause other than none, `m_mem_rd` and `m_mem_wr` are low, and in the following cycle `wb_we` is low.
- R6: `brk_hit` is high exactly in the cycles when the memory-stage cause is breakpoint.
- R7: `redirect` is high exactly when the memory-stage cause is not none, and `redirect_pc` then equals the memory-stage address plus 4.
- R8: On the edge after `redirect`, the fetch, decode, execute and memory stages all load bubbles and the fetch input is ignored. A second trap that was younger than the first never commits.
- R9: The instruction in writeback while a trap sits in the memory stage keeps its register write.
- R10: Decode strobes: a load (opcode 0x23) reads memory and writes rt; a store (opcode 0x2B) writes memory; addi/addiu (opcode 0x08/0x09) write rt; an R-type non-trap instruction writes rd. Register 0 is never written. `wb_rd` carries the destination one cycle after the memory stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | Fetch slot holds a real instruction |
| fetch_instr | input | 32 | Fetched instruction word |
| fetch_addr | input | 32 | Address of the fetched instruction |
| f_addr | output | 32 | Fetch stage address |
| f_cause | output | 2 | Fetch stage cause |
| d_addr | output | 32 | Decode stage address |
| d_cause | output | 2 | Decode stage cause |
| e_addr | output | 32 | Execute stage address |
| e_cause | output | 2 | Execute stage cause |
| m_addr | output | 32 | Memory stage address |
| m_cause | output | 2 | Memory stage cause |
| m_instr | output | 32 | Memory stage instruction word |
| m_mem_rd | output | 1 | Data read strobe, held low on a trap |
| m_mem_wr | output | 1 | Data write strobe, held low on a trap |
| wb_we | output | 1 | Writeback register write enable |
| wb_rd | output | 5 | Writeback destination register |
| redirect | output | 1 | Program counter redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| brk_hit | output | 1 | Breakpoint reached pulse |

## Verification
The bench sends a system call followed by two stores and an addi. If the squash or the flush were wrong, a store would pulse `m_mem_wr` or the addi would reach `wb_we`. Two traps sent back to back check that the younger breakpoint is flushed: a design that cleared too few stages would raise a second redirect to the wrong target. The bench also checks the load that comes just before a breakpoint. That load must still write back, and a flush that reached into writeback would drop the write. A disabled fetch slot loaded with a system-call word must stay a bubble. Decoding an invalid slot would show up as a spurious redirect.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN = 32;
  localparam int REGW = 5;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_BREAK   = 2'd1,
    CAUSE_SYSCALL = 2'd2
  } cause_e;

  typedef struct packed {
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] addr;
    cause_e          cause;
    logic            rd_mem;
    logic            wr_mem;
    logic            wr_reg;
    logic [REGW-1:0] dst;
  } stage_t;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_ADDI    = 6'h08;
  localparam logic [5:0] OP_ADDIU   = 6'h09;
  localparam logic [5:0] OP_LOAD    = 6'h23;
  localparam logic [5:0] OP_STORE   = 6'h2B;
  localparam logic [5:0] FN_SYSCALL = 6'd12;
  localparam logic [5:0] FN_BREAK   = 6'd13;
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_pkg::*;
(
  input  stage_t fin,
  output stage_t dout
);
  logic [5:0]      opc;
  logic [5:0]      fn;
  logic [REGW-1:0] rt;
  logic [REGW-1:0] rd;
  cause_e          trap_c;

  assign opc = fin.instr[31:26];
  assign fn  = fin.instr[5:0];
  assign rt  = fin.instr[20:16];
  assign rd  = fin.instr[15:11];

  always_comb begin
    trap_c = CAUSE_NONE;
    if (opc == OP_SPECIAL) begin
      if (fn == FN_SYSCALL)    trap_c = CAUSE_SYSCALL;
      else if (fn == FN_BREAK) trap_c = CAUSE_BREAK;
    end
  end

  always_comb begin
    dout        = fin;
    dout.rd_mem = 1'b0;
    dout.wr_mem = 1'b0;
    dout.wr_reg = 1'b0;
    dout.dst    = '0;
    // an earlier recorded cause wins over a newly decoded one
    if (fin.cause == CAUSE_NONE) dout.cause = trap_c;
    unique case (opc)
      OP_SPECIAL: begin
        if (trap_c == CAUSE_NONE && rd != '0) begin
          dout.wr_reg = 1'b1;
          dout.dst    = rd;
        end
      end
      OP_LOAD: begin
        dout.rd_mem = 1'b1;
        if (rt != '0) begin
          dout.wr_reg = 1'b1;
          dout.dst    = rt;
        end
      end
      OP_STORE: dout.wr_mem = 1'b1;
      OP_ADDI, OP_ADDIU: begin
        if (rt != '0) begin
          dout.wr_reg = 1'b1;
          dout.dst    = rt;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_mem_gate.sv
module trap_mem_gate
  import trap_pkg::*;
(
  input  cause_e m_cause_i,
  input  logic   m_rd_i,
  input  logic   m_wr_i,
  input  logic   m_we_i,
  output logic   mem_rd_o,
  output logic   mem_wr_o,
  output logic   reg_we_o
);
  logic live;

  assign live     = (m_cause_i == CAUSE_NONE);
  assign mem_rd_o = m_rd_i & live;
  assign mem_wr_o = m_wr_i & live;
  assign reg_we_o = m_we_i & live;
endmodule

// File: rtl/trap_flush_ctrl.sv
module trap_flush_ctrl
  import trap_pkg::*;
#(
  parameter int AW      = XLEN,
  parameter int INSTR_B = 4
) (
  input  cause_e        m_cause_i,
  input  logic [AW-1:0] m_addr_i,
  output logic          flush_o,
  output logic [AW-1:0] target_o,
  output logic          brk_o
);
  localparam logic [AW-1:0] STEP = AW'(INSTR_B);

  assign flush_o  = (m_cause_i != CAUSE_NONE);
  assign brk_o    = (m_cause_i == CAUSE_BREAK);
  assign target_o = m_addr_i + STEP;
endmodule

// File: rtl/trap_pipe_top.sv
module trap_pipe_top
  import trap_pkg::*;
#(
  parameter int AW   = XLEN,
  parameter int RW   = REGW,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [31:0]   fetch_instr,
  input  logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] f_addr,
  output logic [1:0]    f_cause,
  output logic [AW-1:0] d_addr,
  output logic [1:0]    d_cause,
  output logic [AW-1:0] e_addr,
  output logic [1:0]    e_cause,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_cause,
  output logic [31:0]   m_instr,
  output logic          m_mem_rd,
  output logic          m_mem_wr,
  output logic          wb_we,
  output logic [RW-1:0] wb_rd,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc,
  output logic          brk_hit
);
  localparam stage_t BUBBLE = stage_t'('0);

  // reset: asserted asynchronously, released through a flop chain
  logic [SYNC-1:0] rst_pipe;
  logic            rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC-1];

  stage_t f_q, d_q, e_q, m_q;
  stage_t f_n, d_n, e_n, m_n, f_in, dec_out;
  logic          w_we_q, w_we_n;
  logic [RW-1:0] w_rd_q, w_rd_n;
  logic          flush, gate_we;

  always_comb begin
    f_in = BUBBLE;
    if (fetch_valid) begin
      f_in.instr = fetch_instr;
      f_in.addr  = fetch_addr;
      f_in.cause = CAUSE_NONE;
    end
  end

  trap_decode u_dec (
    .fin  (f_q),
    .dout (dec_out)
  );

  trap_mem_gate u_gate (
    .m_cause_i (m_q.cause),
    .m_rd_i    (m_q.rd_mem),
    .m_wr_i    (m_q.wr_mem),
    .m_we_i    (m_q.wr_reg),
    .mem_rd_o  (m_mem_rd),
    .mem_wr_o  (m_mem_wr),
    .reg_we_o  (gate_we)
  );

  trap_flush_ctrl #(.AW(AW)) u_flush (
    .m_cause_i (m_q.cause),
    .m_addr_i  (m_q.addr),
    .flush_o   (flush),
    .target_o  (redirect_pc),
    .brk_o     (brk_hit)
  );

  // next state: either shift or flush every younger stage
  always_comb begin
    if (flush) begin
      f_n = BUBBLE;
      d_n = BUBBLE;
      e_n = BUBBLE;
      m_n = BUBBLE;
    end else begin
      f_n = f_in;
      d_n = dec_out;
      e_n = d_q;
      m_n = e_q;
    end
    w_we_n = gate_we;
    w_rd_n = m_q.dst;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      f_q    <= BUBBLE;
      d_q    <= BUBBLE;
      e_q    <= BUBBLE;
      m_q    <= BUBBLE;
      w_we_q <= 1'b0;
      w_rd_q <= '0;
    end else begin
      f_q    <= f_n;
      d_q    <= d_n;
      e_q    <= e_n;
      m_q    <= m_n;
      w_we_q <= w_we_n;
      w_rd_q <= w_rd_n;
    end
  end

  assign f_addr   = f_q.addr;
  assign f_cause  = f_q.cause;
  assign d_addr   = d_q.addr;
  assign d_cause  = d_q.cause;
  assign e_addr   = e_q.addr;
  assign e_cause  = e_q.cause;
  assign m_addr   = m_q.addr;
  assign m_cause  = m_q.cause;
  assign m_instr  = m_q.instr;
  assign wb_we    = w_we_q;
  assign wb_rd    = w_rd_q;
  assign redirect = flush;

  assert_wb_squash_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect |=> !wb_we);
  assert_no_access_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect |-> (!m_mem_rd && !m_mem_wr));
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect |=> (f_cause == 2'd0 && d_cause == 2'd0 && e_cause == 2'd0 &&
                  m_cause == 2'd0 && f_addr == '0 && m_addr == '0));
  assert_keep_cause_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (d_cause != 2'd0 && !redirect) |=> (e_cause == $past(d_cause)));
  assert_brk_redirect_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_hit |-> redirect);
endmodule

// File: tb/sim_trap_pipe_top.sv
module sim_trap_pipe_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_instr, fetch_addr;
  logic [31:0] f_addr, d_addr, e_addr, m_addr, m_instr, redirect_pc;
  logic [1:0]  f_cause, d_cause, e_cause, m_cause;
  logic        m_mem_rd, m_mem_wr, wb_we, redirect, brk_hit;
  logic [4:0]  wb_rd;

  int checks = 0;
  int errors = 0;
  int stray  = 0;
  bit mon_en = 0;
  bit done   = 0;

  localparam logic [31:0] W_NOP     = 32'h0000_0000;
  localparam logic [31:0] W_SYSCALL = 32'h0000_000C;
  localparam logic [31:0] W_BREAK   = 32'h0000_000D;
  localparam logic [31:0] W_ADDI5   = 32'h2005_0001;
  localparam logic [31:0] W_ADDI6   = 32'h2006_0002;
  localparam logic [31:0] W_ADDI7   = 32'h2007_0003;
  localparam logic [31:0] W_SW      = 32'hAC05_0000;
  localparam logic [31:0] W_LW8     = 32'h8C08_0000;
  localparam logic [31:0] W_ADD9    = 32'h0000_4820;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_pipe_top u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .fetch_instr(fetch_instr), .fetch_addr(fetch_addr),
    .f_addr(f_addr), .f_cause(f_cause), .d_addr(d_addr), .d_cause(d_cause),
    .e_addr(e_addr), .e_cause(e_cause), .m_addr(m_addr), .m_cause(m_cause),
    .m_instr(m_instr), .m_mem_rd(m_mem_rd), .m_mem_wr(m_mem_wr),
    .wb_we(wb_we), .wb_rd(wb_rd), .redirect(redirect),
    .redirect_pc(redirect_pc), .brk_hit(brk_hit)
  );

  // stray writes while a flushed window is being watched
  always @(negedge clk) begin
    if (mon_en && m_mem_wr) stray++;
    if (mon_en && wb_we && wb_rd == 5'd6) stray++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [31:0] ins, input logic [31:0] a);
    fetch_valid = v;
    fetch_instr = ins;
    fetch_addr  = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, W_NOP, 32'h0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_valid = 1'b0; fetch_instr = '0; fetch_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset f_addr", f_addr, 32'h0);
    chk("R1 reset m_cause", {30'h0, m_cause}, 32'h0);
    chk("R1 reset strobes", {27'h0, m_mem_rd, m_mem_wr, wb_we, redirect, brk_hit}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    // Scenario A: system call followed by stores
    mon_en = 1;
    cyc(1, W_ADDI5, 32'h100);
    chk("R3 fetch addr", f_addr, 32'h100);
    cyc(1, W_SYSCALL, 32'h104);
    chk("R3 fetch cause none", {30'h0, f_cause}, 32'h0);
    cyc(1, W_SW, 32'h108);
    chk("R2 decode syscall cause", {30'h0, d_cause}, 32'd2);
    chk("R3 execute addr", e_addr, 32'h100);
    cyc(1, W_SW, 32'h10C);
    chk("R3 cause moves to E", {30'h0, e_cause}, 32'd2);
    chk("R7 no redirect yet", {31'h0, redirect}, 32'h0);
    cyc(1, W_ADDI6, 32'h110);
    chk("R7 redirect on syscall", {31'h0, redirect}, 32'h1);
    chk("R7 redirect target", redirect_pc, 32'h108);
    chk("R6 no break on syscall", {31'h0, brk_hit}, 32'h0);
    chk("R5 no store strobe", {31'h0, m_mem_wr}, 32'h0);
    chk("R9 older writeback kept", {26'h0, wb_we, wb_rd}, {26'h0, 1'b1, 5'd5});
    cyc(1, W_ADDI6, 32'h114);
    chk("R8 fetch input ignored", f_addr, 32'h0);
    chk("R8 decode cleared", {d_addr[29:0], d_cause}, 32'h0);
    chk("R8 execute cleared", {e_addr[29:0], e_cause}, 32'h0);
    chk("R8 memory cleared", m_addr, 32'h0);
    chk("R5 trap writes no reg", {31'h0, wb_we}, 32'h0);
    chk("R7 redirect drops", {31'h0, redirect}, 32'h0);
    cyc(1, W_ADDI7, 32'h108);
    chk("R3 restart fetch", f_addr, 32'h108);
    idle(3);
    chk("R3 restart in M", m_addr, 32'h108);
    idle(1);
    chk("R10 addi writes rt", {26'h0, wb_we, wb_rd}, {26'h0, 1'b1, 5'd7});
    mon_en = 0;
    chk("R5 no younger store or write", stray, 0);

    // Scenario B: load then breakpoint
    cyc(1, W_LW8, 32'h1FC);
    cyc(1, W_BREAK, 32'h200);
    cyc(1, W_ADD9, 32'h204);
    cyc(0, W_NOP, 32'h0);
    chk("R10 load reads", {30'h0, m_mem_rd, m_mem_wr}, 32'h2);
    chk("R2 decode break cause", {30'h0, e_cause}, 32'd1);
    chk("R2 add has no cause", {30'h0, d_cause}, 32'd0);
    cyc(0, W_NOP, 32'h0);
    chk("R6 break pulse", {31'h0, brk_hit}, 32'h1);
    chk("R7 break target", redirect_pc, 32'h204);
    chk("R5 no read on trap", {31'h0, m_mem_rd}, 32'h0);
    chk("R9 load writes back", {26'h0, wb_we, wb_rd}, {26'h0, 1'b1, 5'd8});
    cyc(0, W_NOP, 32'h0);
    chk("R6 break pulse ends", {31'h0, brk_hit}, 32'h0);
    chk("R5 break writes no reg", {31'h0, wb_we}, 32'h0);
    idle(4);
    chk("R8 add flushed", {31'h0, wb_we}, 32'h0);

    // Scenario C: disabled slots holding a trap word
    for (int i = 0; i < 5; i++) begin
      cyc(0, W_SYSCALL, 32'h500 + 32'(i*4));
      chk("R4 bubble fetch", {f_addr[29:0], f_cause}, 32'h0);
      chk("R4 no redirect", {31'h0, redirect}, 32'h0);
    end

    // Scenario D: two traps back to back
    cyc(1, W_SYSCALL, 32'h300);
    cyc(1, W_BREAK, 32'h304);
    idle(2);
    chk("R7 first trap commits", redirect_pc, 32'h304);
    chk("R3 second trap behind", {30'h0, e_cause}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      idle(1);
      chk("R8 younger trap removed", {30'h0, redirect, brk_hit}, 32'h0);
    end

    // Scenario E: plain store and R-type
    cyc(1, W_SW, 32'h400);
    cyc(1, W_ADD9, 32'h404);
    idle(2);
    chk("R10 store writes memory", {30'h0, m_mem_rd, m_mem_wr}, 32'h1);
    chk("R10 store m_instr", m_instr, W_SW);
    idle(2);
    chk("R10 R-type writes rd", {26'h0, wb_we, wb_rd}, {26'h0, 1'b1, 5'd9});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule